// File: doc/BRIEF.md
# Element Bit and Byte Reversal Unit

This block rearranges the bits of one element held in a 64-bit lane. The element width is chosen per operation from 8, 16, 32 or 64 bits. Three rearrangements are available: mirror every bit of the element end to end, mirror the bits inside each byte while leaving the bytes where they are, or mirror the order of the bytes while leaving each byte intact. A fourth code copies the element through unchanged. Lane bits at or above the element width are always cleared in the result.

The datapath is combinational and feeds a single output register. An operation is presented together with a one-cycle `in_valid` pulse. The result and `out_valid` appear on the next clock edge. The latency is fixed at one cycle and there is no back-pressure. The consumer must take `out_data` on every cycle in which `out_valid` is high, and a new operation may be started on every cycle. When no operation is presented, the output register keeps its last result.

The full mirror is not built as a separate network. It is the in-byte mirror followed by the byte-order network, and the swap stages of that network are switched on according to the element width.

Top module: `elem_rev_unit`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `out_data` is all zeros.
- R2: `out_valid` is high in exactly those cycles that follow a clock edge at which `in_valid` was high.
- R3: Op code 2'b01 gives the in-byte mirror: within the element, bit 8*b+j of the result equals bit 8*b+7-j of the operand, whatever the element width.
- R4: Op code 2'b10 gives the byte mirror: result byte b equals operand byte n-1-b, where n is the element width in bytes. With an 8-bit element the result byte equals the operand byte.
- R5: Op code 2'b00 gives the full mirror: result bit i equals operand bit W-1-i, where W is the element width.
- R6: Op code 2'b11 copies the element of the operand to the result unchanged.
- R7: The element width code is 2'b00 = 8, 2'b01 = 16, 2'b10 = 32 and 2'b11 = 64 bits. Every result bit at position W or above is 0, whatever the operand holds there.
- R8: An edge at which `in_valid` is low leaves `out_data` unchanged. This holds for any op, width or operand present at that edge.
- R9: With an 8-bit element, the full mirror (op 2'b00) and the in-byte mirror (op 2'b01) give the same result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe; inputs are sampled at the edge where it is high |
| in_sew | input | 2 | Element width code (see R7) |
| in_op | input | 2 | Operation code (see R3 to R6) |
| in_data | input | 64 | Operand lane; the element sits in the low W bits |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_data | output | 64 | Registered result; bits at or above W are cleared |

## Verification
Two functions act in the same cycle on every operation: the rearrangement itself and the clearing of lane bits above the element width. A mistake in one can hide a mistake in the other. The bench therefore drives operands with dense, nonzero upper bytes under every narrow width, and it does so for all four op codes. The reference model mirrors the element and then clears the upper part, and the registered result must match it both in the low element bits and in the zero upper bits. Idle cycles with changing inputs are mixed between busy ones, so the hold behaviour is judged in the same runs.

// File: rtl/elem_rev_pkg.sv
package elem_rev_pkg;

  typedef enum logic [1:0] {
    OP_FULL_MIRROR = 2'b00,
    OP_BYTE_BITS   = 2'b01,
    OP_BYTE_ORDER  = 2'b10,
    OP_PASS        = 2'b11
  } rev_op_e;

  localparam int SEW_CODE_W = 2;

endpackage

// File: rtl/byte_bit_mirror.sv
// Mirrors the bits inside every byte with three swap stages:
// single bits, then bit pairs, then nibbles.
module byte_bit_mirror #(
  parameter int LANE_W = 64
) (
  input  logic [LANE_W-1:0] din,
  output logic [LANE_W-1:0] dout
);
  localparam int NSTAGE = 3;

  logic [NSTAGE:0][LANE_W-1:0] stg;

  assign stg[0] = din;

  for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
    localparam int SPAN = 1 << s;
    for (genvar i = 0; i < LANE_W; i++) begin : g_bit
      assign stg[s+1][i] = stg[s][i ^ SPAN];
    end
  end

  assign dout = stg[NSTAGE];

endmodule

// File: rtl/byte_order_net.sv
// Byte-order network: stage k swaps neighbouring blocks of 8<<k bits.
// Stage k is active only when the element width code exceeds k.
module byte_order_net #(
  parameter int LANE_W = 64,
  parameter int SEW_W  = 2
) (
  input  logic [SEW_W-1:0]  sew,
  input  logic [LANE_W-1:0] din,
  output logic [LANE_W-1:0] dout
);
  localparam int NBYTES = LANE_W / 8;
  localparam int NSTAGE = $clog2(NBYTES);

  logic [NSTAGE:0][LANE_W-1:0] stg;

  assign stg[0] = din;

  for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
    localparam int SPAN = 8 << k;
    logic en;
    assign en = (32'(sew) > k);
    for (genvar i = 0; i < LANE_W; i++) begin : g_bit
      assign stg[k+1][i] = en ? stg[k][i ^ SPAN] : stg[k][i];
    end
  end

  assign dout = stg[NSTAGE];

endmodule

// File: rtl/elem_width_mask.sv
// Builds the keep mask for the active element: byte b is kept when
// b lies below the element width in bytes.
module elem_width_mask #(
  parameter int LANE_W = 64,
  parameter int SEW_W  = 2
) (
  input  logic [SEW_W-1:0]  sew,
  output logic [LANE_W-1:0] keep
);
  localparam int NBYTES = LANE_W / 8;

  logic [31:0] elem_bytes;
  assign elem_bytes = 32'd1 << sew;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign keep[b*8 +: 8] = (32'(b) < elem_bytes) ? 8'hFF : 8'h00;
  end

endmodule

// File: rtl/elem_rev_unit.sv
module elem_rev_unit #(
  parameter int LANE_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        in_sew,
  input  logic [1:0]        in_op,
  input  logic [LANE_W-1:0] in_data,
  output logic              out_valid,
  output logic [LANE_W-1:0] out_data
);
  import elem_rev_pkg::*;

  localparam int SEW_W = SEW_CODE_W;

  rev_op_e           op;
  logic [LANE_W-1:0] bits_mirrored;
  logic [LANE_W-1:0] order_in;
  logic [LANE_W-1:0] order_out;
  logic [LANE_W-1:0] keep;
  logic [LANE_W-1:0] pick;
  logic [LANE_W-1:0] res_d;

  assign op = rev_op_e'(in_op);

  byte_bit_mirror #(.LANE_W(LANE_W)) u_bits (
    .din  (in_data),
    .dout (bits_mirrored)
  );

  // The full mirror reuses the byte-order network on the mirrored bytes.
  assign order_in = (op == OP_FULL_MIRROR) ? bits_mirrored : in_data;

  byte_order_net #(.LANE_W(LANE_W), .SEW_W(SEW_W)) u_order (
    .sew  (in_sew),
    .din  (order_in),
    .dout (order_out)
  );

  elem_width_mask #(.LANE_W(LANE_W), .SEW_W(SEW_W)) u_mask (
    .sew  (in_sew),
    .keep (keep)
  );

  always_comb begin
    unique case (op)
      OP_FULL_MIRROR: pick = order_out;
      OP_BYTE_BITS:   pick = bits_mirrored;
      OP_BYTE_ORDER:  pick = order_out;
      default:        pick = in_data;
    endcase
    res_d = pick & keep;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= res_d;
    end
  end

endmodule

// File: rtl/elem_rev_chk.sv
module elem_rev_chk #(
  parameter int LANE_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [1:0]        in_sew,
  input logic [1:0]        in_op,
  input logic [LANE_W-1:0] in_data,
  input logic              out_valid,
  input logic [LANE_W-1:0] out_data
);
  function automatic logic [LANE_W-1:0] width_keep(input logic [1:0] s);
    logic [LANE_W-1:0] m;
    m = '0;
    for (int b = 0; b < LANE_W / 8; b++)
      if (b < (1 << s)) m[b*8 +: 8] = 8'hFF;
    return m;
  endfunction

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data));

  a_r7_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ((out_data & ~width_keep($past(in_sew))) == '0));

  a_r6_pass_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 2'b11) |=>
      (out_data == ($past(in_data) & width_keep($past(in_sew)))));

  a_r4_narrow_byte_order: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 2'b10 && in_sew == 2'b00) |=>
      (out_data == ($past(in_data) & LANE_W'(8'hFF))));

endmodule

bind elem_rev_unit elem_rev_chk #(.LANE_W(LANE_W)) u_elem_rev_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_sew    (in_sew),
  .in_op     (in_op),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/tb_elem_rev_unit.sv
module tb_elem_rev_unit;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  in_sew;
  logic [1:0]  in_op;
  logic [63:0] in_data;
  logic        out_valid;
  logic [63:0] out_data;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  logic [63:0] exp_data = '0;

  elem_rev_unit #(.LANE_W(64)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sew(in_sew),
    .in_op(in_op), .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
  );

  initial begin
    clk = 0;
    forever #2.5 clk = ~clk;
  end

  function automatic logic [63:0] ref_model(input logic [1:0] op,
                                             input logic [1:0] sew,
                                             input logic [63:0] x);
    int w;
    logic [63:0] e, r;
    w = 8 << sew;
    e = (w == 64) ? x : (x & ((64'd1 << w) - 64'd1));
    r = '0;
    case (op)
      2'b00: for (int i = 0; i < w; i++) r[i] = e[w-1-i];
      2'b01: for (int i = 0; i < w; i++) r[i] = e[(i/8)*8 + 7 - (i%8)];
      2'b10: for (int b = 0; b < w/8; b++) r[b*8 +: 8] = e[(w/8-1-b)*8 +: 8];
      default: r = e;
    endcase
    return r;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string op_tag(input logic [1:0] op);
    case (op)
      2'b00: return "R5 full mirror";
      2'b01: return "R3 in-byte mirror";
      2'b10: return "R4 byte mirror";
      default: return "R6 pass";
    endcase
  endfunction

  // Called at a negative edge: drive, cross one rising edge, compare at the next negative edge.
  task automatic step(input logic v, input logic [1:0] op, input logic [1:0] sew,
                      input logic [63:0] d);
    logic [63:0] upper;
    in_valid = v; in_op = op; in_sew = sew; in_data = d;
    @(posedge clk);
    if (v) exp_data = ref_model(op, sew, d);
    @(negedge clk);
    check("R2 out_valid", {63'd0, out_valid}, {63'd0, v});
    if (v) begin
      check(op_tag(op), out_data, exp_data);
      upper = ((8 << sew) == 64) ? 64'd0 : ~((64'd1 << (8 << sew)) - 64'd1);
      check("R7 upper bits clear", out_data & upper, 64'd0);
    end else begin
      check("R8 hold while idle", out_data, exp_data);
    end
  endtask

  initial begin
    in_valid = 0; in_op = 0; in_sew = 0; in_data = '0;
    rst_n = 0;
    @(negedge clk);
    in_valid = 1; in_data = 64'hFFFF_FFFF_FFFF_FFFF; in_op = 2'b11; in_sew = 2'b11;
    @(negedge clk);
    check("R1 reset out_valid", {63'd0, out_valid}, 64'd0);
    check("R1 reset out_data", out_data, 64'd0);
    in_valid = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // Directed cases, dirty upper bytes on narrow widths
    step(1, 2'b00, 2'b11, 64'h0123_4567_89AB_CDEF);
    step(1, 2'b00, 2'b01, 64'hDEAD_BEEF_CAFE_0001);
    step(1, 2'b01, 2'b10, 64'hFFFF_0000_8040_2010);
    step(1, 2'b10, 2'b10, 64'hAAAA_5555_1122_3344);
    step(1, 2'b10, 2'b11, 64'h0102_0304_0506_0708);
    step(1, 2'b10, 2'b00, 64'h7777_7777_7777_77A5);
    step(1, 2'b11, 2'b01, 64'hFEDC_BA98_7654_3210);
    step(0, 2'b00, 2'b11, 64'hFFFF_FFFF_FFFF_FFFF);
    step(0, 2'b10, 2'b00, 64'h1234_5678_9ABC_DEF0);

    // R9: 8-bit full mirror equals 8-bit in-byte mirror
    for (int k = 0; k < 4; k++) begin
      logic [63:0] v, a;
      v = {$urandom, $urandom};
      step(1, 2'b00, 2'b00, v);
      a = out_data;
      step(1, 2'b01, 2'b00, v);
      check("R9 narrow full vs in-byte", a, out_data);
    end

    // Mixed stream, back-to-back and idle cycles
    for (int n = 0; n < 3000; n++) begin
      logic [63:0] v;
      v = {$urandom, $urandom};
      step(logic'(($urandom % 4) != 0), 2'($urandom), 2'($urandom), v);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule